// File: doc/BRIEF.md
# Boot Configuration Stream Parser

This block interprets the byte stream fetched from an optional serial configuration memory at power-up. A fetch engine hands it bytes one at a time with a valid strobe, together with a flag saying whether a memory answered at all and end-of-data and fetch-error indications. The parser checks two marker bytes, captures an interface-configuration byte and a flag-polarity byte, reads a little-endian descriptor length and then picks one of three outcomes: forward a full descriptor on an indexed write port, capture a short vendor/product/device identifier set, or hand descriptor supply over to an external host.

A `start` pulse opens a parse. Each parse ends in a single-cycle `done` pulse carrying the chosen outcome, plus either an enumeration-complete pulse (a load from memory succeeded) or a ready pulse (the host must take over). A malformed or truncated stream raises a sticky error flag and ends on the host outcome.

Top module: `cfg_stream_parser`

## Requirements
- R1: After reset `done`, `enum_ok`, `host_rdy`, `err` and `dsc_we` are low and `ifcfg`/`polar` hold their parameter defaults (0x00 and 0x00 by default).
- R2: When `start` is seen with `mem_present` low, `done` pulses one cycle later with outcome host (code 3), `host_rdy` pulses with it, and `ifcfg`/`polar` keep their values.
- R3: If the first byte is not 0xC4, the parse ends right after that byte on outcome host with `err` low, and `ifcfg`/`polar` are unchanged.
- R4: With a valid first byte, the second and third bytes are loaded into `ifcfg` and `polar` respectively.
- R5: If the fourth byte is not 0xC4, the parse ends after it on outcome host with `err` low, keeping the values loaded by R4.
- R6: The fifth and sixth bytes form the length, low byte first; a length of exactly 6 takes the short outcome (code 2): the next six bytes load `vid`, `pid`, `did` in that order, each low byte first, and `done` comes with `enum_ok`.
- R7: Any other accepted length L gives the full outcome (code 1): the next L bytes appear on `dsc_dat` with `dsc_we` and `dsc_idx` counting 0 to L-1, one cycle after each byte, and `done` with `enum_ok` follows the last byte by one cycle.
- R8: A length of 0 or above 500 sets `err` and ends on outcome host with `host_rdy`; a length of exactly 500 is accepted.
- R9: `stream_end` or `stream_err` during a parse, before the expected bytes are all in, sets `err` and ends on outcome host without `enum_ok`.
- R10: `done` is high for exactly one cycle per parse and `done_path` never carries code 0 with it.
- R11: Bytes offered while no parse is running produce no write and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a parse when idle |
| mem_present | input | 1 | A configuration memory answered |
| byte_vld | input | 1 | `byte_dat` carries the next byte |
| byte_dat | input | 8 | Stream byte |
| stream_end | input | 1 | No more bytes will come |
| stream_err | input | 1 | The fetch failed |
| ifcfg | output | 8 | Interface-configuration value |
| polar | output | 8 | Flag-polarity value |
| vid | output | 16 | Vendor identifier (short outcome) |
| pid | output | 16 | Product identifier (short outcome) |
| did | output | 16 | Device identifier (short outcome) |
| dsc_we | output | 1 | Descriptor byte write strobe |
| dsc_idx | output | 9 | Descriptor byte index |
| dsc_dat | output | 8 | Descriptor byte |
| done | output | 1 | One-cycle end-of-parse pulse |
| done_path | output | 2 | Outcome: 1 full, 2 short, 3 host |
| enum_ok | output | 1 | Load from memory completed |
| host_rdy | output | 1 | Host must supply the descriptor |
| err | output | 1 | Sticky error, cleared by `start` |

## Verification
The parser is driven with streams that differ at each decision point: no memory, a bad first marker, a bad second marker, a length of six, an ordinary length and the limit of 500, lengths of 0 and 501, and a stream cut off or failed in the header and in the payload. Each pattern separates one outcome from its neighbours through the outcome code, the error flag and which of the two completion pulses fires, while payload contents and indices are compared byte by byte against a computed pattern. Bytes sent after a parse has ended show that idle traffic touches nothing.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   typedef enum logic [1:0] {
      PATH_NONE  = 2'd0,
      PATH_FULL  = 2'd1,
      PATH_SHORT = 2'd2,
      PATH_HOST  = 2'd3
   } path_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HDR  = 2'd1,
      ST_BODY = 2'd2
   } pstate_e;

   localparam int HDR_BYTES = 6;
endpackage

// File: rtl/cfgp_bytecnt.sv
module cfgp_bytecnt #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/cfgp_idregs.sv
module cfgp_idregs #(
   parameter int BYTE_W   = 8,
   parameter int ID_WORDS = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [$clog2(2*ID_WORDS)-1:0]  sel,
   input  logic [BYTE_W-1:0]              dat,
   output logic [ID_WORDS*2*BYTE_W-1:0]   ids
);
   localparam int WORD_W = 2 * BYTE_W;

   generate
      if (ID_WORDS < 1) begin : g_bad
         $error("ID_WORDS must be at least 1");
      end
      for (genvar w = 0; w < ID_WORDS; w++) begin : g_word
         for (genvar b = 0; b < 2; b++) begin : g_byte
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  ids[w*WORD_W + b*BYTE_W +: BYTE_W] <= '0;
               else if (we && (int'(sel) == 2*w + b))
                  ids[w*WORD_W + b*BYTE_W +: BYTE_W] <= dat;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
   import cfgp_pkg::*;
#(
   parameter int          BYTE_W    = 8,
   parameter int          LEN_W     = 16,
   parameter int          MAX_LEN   = 500,
   parameter int          SHORT_LEN = 6,
   parameter logic [7:0]  MARK      = 8'hC4,
   parameter logic [7:0]  IFCFG_RST = 8'h00,
   parameter logic [7:0]  POLAR_RST = 8'h00,
   localparam int         IDX_W     = $clog2(MAX_LEN),
   localparam int         ID_WORDS  = SHORT_LEN / 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               mem_present,
   input  logic               byte_vld,
   input  logic [BYTE_W-1:0]  byte_dat,
   input  logic               stream_end,
   input  logic               stream_err,
   output logic [BYTE_W-1:0]  ifcfg,
   output logic [BYTE_W-1:0]  polar,
   output logic [15:0]        vid,
   output logic [15:0]        pid,
   output logic [15:0]        did,
   output logic               dsc_we,
   output logic [IDX_W-1:0]   dsc_idx,
   output logic [BYTE_W-1:0]  dsc_dat,
   output logic               done,
   output logic [1:0]         done_path,
   output logic               enum_ok,
   output logic               host_rdy,
   output logic               err
);
   localparam int SEL_W = $clog2(SHORT_LEN);

   generate
      if (BYTE_W != 8)            begin : g_bw  $error("BYTE_W must be 8"); end
      if (MAX_LEN <= SHORT_LEN)   begin : g_ml  $error("MAX_LEN too small"); end
      if (SHORT_LEN != 6)         begin : g_sl  $error("SHORT_LEN must be 6 for three IDs"); end
      if (LEN_W != 2 * BYTE_W)    begin : g_lw  $error("LEN_W must be two bytes"); end
   endgenerate

   pstate_e           st;
   logic [IDX_W-1:0]  cnt;
   logic [LEN_W-1:0]  len_q;
   logic [BYTE_W-1:0] len_lo;
   logic              short_q;
   logic              abort, take, cnt_clr, last_body;
   logic [LEN_W-1:0]  len_new, cnt_ext;
   logic [ID_WORDS*16-1:0] ids;

   assign abort     = (st != ST_IDLE) && (stream_end || stream_err);
   assign take      = (st != ST_IDLE) && byte_vld && !abort;
   assign len_new   = {byte_dat, len_lo};
   assign cnt_ext   = {{(LEN_W-IDX_W){1'b0}}, cnt};
   assign last_body = (cnt_ext == len_q - 16'd1);
   assign cnt_clr   = (st == ST_IDLE) ||
                      (st == ST_HDR && take && int'(cnt) == HDR_BYTES - 1);

   cfgp_bytecnt #(.CNT_W(IDX_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(take), .cnt(cnt)
   );

   cfgp_idregs #(.BYTE_W(BYTE_W), .ID_WORDS(ID_WORDS)) u_ids (
      .clk(clk), .rst_n(rst_n),
      .we(st == ST_BODY && short_q && take),
      .sel(cnt[SEL_W-1:0]), .dat(byte_dat), .ids(ids)
   );

   assign vid = ids[15:0];
   assign pid = ids[31:16];
   assign did = ids[47:32];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ifcfg     <= IFCFG_RST;
         polar     <= POLAR_RST;
         len_lo    <= '0;
         len_q     <= '0;
         short_q   <= 1'b0;
         dsc_we    <= 1'b0;
         dsc_idx   <= '0;
         dsc_dat   <= '0;
         done      <= 1'b0;
         done_path <= PATH_NONE;
         enum_ok   <= 1'b0;
         host_rdy  <= 1'b0;
         err       <= 1'b0;
      end else begin
         done     <= 1'b0;
         enum_ok  <= 1'b0;
         host_rdy <= 1'b0;
         dsc_we   <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               err <= 1'b0;
               if (!mem_present) begin
                  done <= 1'b1; done_path <= PATH_HOST; host_rdy <= 1'b1;
               end else begin
                  st <= ST_HDR;
               end
            end
            ST_HDR: if (abort) begin
               err <= 1'b1; st <= ST_IDLE;
               done <= 1'b1; done_path <= PATH_HOST; host_rdy <= 1'b1;
            end else if (take) begin
               case (int'(cnt))
                  0, 3: if (byte_dat != MARK) begin
                     st <= ST_IDLE;
                     done <= 1'b1; done_path <= PATH_HOST; host_rdy <= 1'b1;
                  end
                  1: ifcfg  <= byte_dat;
                  2: polar  <= byte_dat;
                  4: len_lo <= byte_dat;
                  default: begin
                     len_q <= len_new;
                     if (len_new == 16'(SHORT_LEN)) begin
                        short_q <= 1'b1; st <= ST_BODY;
                     end else if (len_new == '0 || len_new > 16'(MAX_LEN)) begin
                        err <= 1'b1; st <= ST_IDLE;
                        done <= 1'b1; done_path <= PATH_HOST; host_rdy <= 1'b1;
                     end else begin
                        short_q <= 1'b0; st <= ST_BODY;
                     end
                  end
               endcase
            end
            ST_BODY: if (abort) begin
               err <= 1'b1; st <= ST_IDLE;
               done <= 1'b1; done_path <= PATH_HOST; host_rdy <= 1'b1;
            end else if (take) begin
               if (!short_q) begin
                  dsc_we <= 1'b1; dsc_idx <= cnt; dsc_dat <= byte_dat;
               end
               if (last_body) begin
                  st <= ST_IDLE; done <= 1'b1; enum_ok <= 1'b1;
                  done_path <= short_q ? PATH_SHORT : PATH_FULL;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R10: completion pulse never lasts two cycles
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10: a completion always carries a real outcome code
   a_r10_path_valid: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> done_path != PATH_NONE);
   // R6 / R7: enumeration-complete only with a memory-loaded outcome
   a_r7_enum_path: assert property (@(posedge clk) disable iff (!rst_n)
      enum_ok |-> done && (done_path == PATH_FULL || done_path == PATH_SHORT));
   // R2: host hand-off pulse only with the host outcome
   a_r2_rdy_host: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdy |-> done && done_path == PATH_HOST && !enum_ok);
   // R8 / R9: an erroneous end never reports a memory load
   a_r9_err_host: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> done_path == PATH_HOST);
   // R7: write index stays inside the declared length
   a_r7_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_we |-> ({{(LEN_W-IDX_W){1'b0}}, dsc_idx} < len_q));
   // R11: idle traffic does not touch the configuration registers
   a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !start) |=> ($stable(ifcfg) && $stable(polar)));
endmodule

// File: tb/cfg_stream_parser_tb.sv
module cfg_stream_parser_tb;
   localparam int CLK_PER = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 0, mem_present = 0, byte_vld = 0, stream_end = 0, stream_err = 0;
   logic [7:0] byte_dat = 8'h00;
   logic [7:0] ifcfg, polar, dsc_dat;
   logic [15:0] vid, pid, did;
   logic dsc_we, done, enum_ok, host_rdy, err;
   logic [8:0] dsc_idx;
   logic [1:0] done_path;

   int checks = 0, errors = 0;
   int done_cnt, enum_cnt, rdy_cnt, wr_cnt, wr_bad, long_done;
   logic [1:0] last_path;
   logic last_err, prev_done;

   always #(CLK_PER/2) clk = ~clk;

   cfg_stream_parser u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_present(mem_present),
      .byte_vld(byte_vld), .byte_dat(byte_dat), .stream_end(stream_end),
      .stream_err(stream_err), .ifcfg(ifcfg), .polar(polar), .vid(vid),
      .pid(pid), .did(did), .dsc_we(dsc_we), .dsc_idx(dsc_idx),
      .dsc_dat(dsc_dat), .done(done), .done_path(done_path),
      .enum_ok(enum_ok), .host_rdy(host_rdy), .err(err)
   );

   function automatic logic [7:0] pat(int i);
      return 8'((i * 13 + 5) & 255);
   endfunction

   always @(negedge clk) begin
      if (done) begin
         done_cnt++; last_path = done_path; last_err = err;
         if (prev_done) long_done++;
      end
      prev_done = done;
      if (enum_ok)  enum_cnt++;
      if (host_rdy) rdy_cnt++;
      if (dsc_we) begin
         if (int'(dsc_idx) != wr_cnt || dsc_dat != pat(wr_cnt)) wr_bad++;
         wr_cnt++;
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clr_mon();
      done_cnt = 0; enum_cnt = 0; rdy_cnt = 0; wr_cnt = 0; wr_bad = 0;
      long_done = 0; last_path = 2'd0; last_err = 1'b0;
   endtask

   task automatic go(logic mem);
      clr_mon();
      @(negedge clk); start = 1; mem_present = mem;
      @(negedge clk); start = 0;
   endtask

   task automatic put(logic [7:0] b);
      @(negedge clk); byte_vld = 1; byte_dat = b;
      @(negedge clk); byte_vld = 0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic expect_end(string req, int path, int e, int en, int rd);
      chk({req, " done count"}, done_cnt, 1);
      chk({req, " path"}, int'(last_path), path);
      chk({req, " err"}, int'(last_err), e);
      chk({req, " enum_ok"}, enum_cnt, en);
      chk({req, " host_rdy"}, rdy_cnt, rd);
      chk("R10 single-cycle done", long_done, 0);
   endtask

   task automatic hdr(logic [7:0] a, logic [7:0] p, int len);
      put(8'hC4); put(a); put(p); put(8'hC4);
      put(8'(len & 255)); put(8'((len >> 8) & 255));
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 done", int'(done), 0);  chk("R1 err", int'(err), 0);
      chk("R1 dsc_we", int'(dsc_we), 0);
      chk("R1 ifcfg", int'(ifcfg), 0); chk("R1 polar", int'(polar), 0);
      chk("R1 enum/rdy", int'(enum_ok) + int'(host_rdy), 0);
   endtask

   task automatic t_nomem();
      go(1'b0); settle();
      expect_end("R2", 3, 0, 0, 1);
      chk("R2 ifcfg kept", int'(ifcfg), 0);
   endtask

   task automatic t_bad_first();
      go(1'b1); put(8'hC3); settle();
      expect_end("R3", 3, 0, 0, 1);
      put(8'hC4); put(8'h77); put(8'h66); settle();
      chk("R3 ifcfg kept", int'(ifcfg), 0);
      chk("R11 idle bytes: ifcfg", int'(ifcfg), 0);
      chk("R11 idle bytes: polar", int'(polar), 0);
      chk("R11 idle bytes: no write", wr_cnt, 0);
      chk("R11 idle bytes: no done", done_cnt, 1);
   endtask

   task automatic t_no_desc();
      go(1'b1); put(8'hC4); put(8'hA5); put(8'h5A); put(8'h12); settle();
      chk("R4 ifcfg", int'(ifcfg), 8'hA5);
      chk("R4 polar", int'(polar), 8'h5A);
      expect_end("R5", 3, 0, 0, 1);
   endtask

   task automatic t_short();
      go(1'b1); hdr(8'h11, 8'h22, 6);
      put(8'h47); put(8'h05); put(8'h02); put(8'h10); put(8'h01); put(8'h00);
      settle();
      expect_end("R6", 2, 0, 1, 0);
      chk("R6 vid", int'(vid), 16'h0547);
      chk("R6 pid", int'(pid), 16'h1002);
      chk("R6 did", int'(did), 16'h0001);
      chk("R6 no descriptor writes", wr_cnt, 0);
      chk("R4 ifcfg", int'(ifcfg), 8'h11);
   endtask

   task automatic t_full(int len, string req);
      go(1'b1); hdr(8'h3C, 8'hC3, len);
      for (int i = 0; i < len - 1; i++) put(pat(i));
      chk({req, " no early done"}, done_cnt, 0);
      @(negedge clk); byte_vld = 1; byte_dat = pat(len - 1);
      @(negedge clk); byte_vld = 0;
      chk({req, " done right after last byte"}, int'(done), 1);
      chk({req, " last index"}, int'(dsc_idx), len - 1);
      settle();
      expect_end(req, 1, 0, 1, 0);
      chk({req, " write count"}, wr_cnt, len);
      chk({req, " bad writes"}, wr_bad, 0);
   endtask

   task automatic t_badlen(int len);
      go(1'b1); hdr(8'h01, 8'h02, len); settle();
      expect_end("R8", 3, 1, 0, 1);
      chk("R8 no writes", wr_cnt, 0);
   endtask

   task automatic t_trunc(logic use_err, int nbytes);
      go(1'b1);
      if (nbytes >= 6) begin
         hdr(8'h0F, 8'hF0, 10);
         for (int i = 0; i < nbytes - 6; i++) put(pat(i));
      end else begin
         put(8'hC4); put(8'h0F);
      end
      @(negedge clk);
      if (use_err) stream_err = 1; else stream_end = 1;
      @(negedge clk); stream_err = 0; stream_end = 0;
      settle();
      expect_end("R9", 3, 1, 0, 1);
   endtask

   initial begin
      clr_mon(); prev_done = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_nomem();
      t_bad_first();
      t_no_desc();
      t_short();
      t_full(10, "R7");
      t_full(500, "R8 limit R7");
      t_badlen(0);
      t_badlen(501);
      t_trunc(1'b0, 10);
      t_trunc(1'b1, 2);
      go(1'b1); put(8'hC4); settle();
      chk("R9 no done while waiting", done_cnt, 0);
      t_trunc(1'b0, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PER * 150000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule